// File: doc/BRIEF.md
# Two-Wire Slave for a 16-bit Register Bank

This block is a slave on a two-wire serial bus (I2C). It sits between the bus pins and a bank of 16-bit registers. It answers at two device addresses. The first is a 7-bit address built from a fixed five-bit prefix and two strap inputs. The second is a generic address that does not depend on the straps. Every transfer on the bus is one byte, so every 16-bit register moves as two bytes: the upper byte first, then the lower byte.

A host writes by sending the device address with the direction bit clear, then a one-byte register pointer, then any number of upper/lower byte pairs. The block stores a register only after both bytes of a pair have arrived. It then steps the pointer on by one.

A host reads by first setting the pointer in a write phase, then issuing a repeated start with the direction bit set. The block then shifts out upper/lower pairs. Each host acknowledge after a lower byte moves the pointer on and fetches the next word. A host not-acknowledge makes the block let go of the data line until the next start.

Both bus lines are synchronized to the system clock and filtered before use. The block drives the data line only through an open-drain enable.

Top module: `i2c_word_slave`

## Requirements
- R1: The block acknowledges a device address equal to {5'b01101, strapHi, strapLo}. It does not acknowledge a non-matching address, and it ignores the rest of that transfer: no acknowledge, no data driven, no register write.
- R2: The block always acknowledges the generic 7-bit address 7'b0001110, whatever the strap levels. Bit 0 of the address byte selects the direction: 0 is a write and 1 is a read.
- R3: In a write, the block acknowledges the pointer byte and each data byte. Each completed pair produces exactly one single-cycle regWrEn pulse, with regWrAddr equal to the pointer and regWrData equal to {first byte, second byte}. Every byte is received most significant bit first.
- R4: After each completed pair the pointer advances by one, wrapping from 8'hFF to 8'h00. Further pairs in the same transfer therefore go to consecutive registers.
- R5: An upper byte that is followed by a stop, before its lower byte completes, causes no register write.
- R6: After a repeated start with the direction bit set, the block sends the word at the pointer: the upper byte, then the lower byte, each most significant bit first. It changes its data-line drive only while the filtered clock is low.
- R7: A host acknowledge after a lower byte advances the pointer and starts the next word. A host not-acknowledge leaves the pointer unchanged, and the block releases the data line until the next start.
- R8: A start or stop condition (a data edge while the clock is high) aborts any byte in progress. After a stop the data line is released, and a partially received byte writes nothing.
- R9: A clock pulse shorter than FILT_LEN system clock cycles is filtered out and does not count as a bit.
- R10: After reset, sdaOe is 0, regWrEn is 0 and regAddr (the pointer) is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| strapHi | input | 1 | Strap that sets address bit 2 |
| strapLo | input | 1 | Strap that sets address bit 1 |
| sdaOe | output | 1 | Pulls the data line low when 1 |
| regAddr | output | 8 | Current register pointer, used as the read address |
| regRdData | input | 16 | Word from the register bank at regAddr |
| regWrEn | output | 1 | One-cycle write strobe |
| regWrAddr | output | 8 | Register address of the write |
| regWrData | output | 16 | Word to write |

## Verification
A wrong pointer shows at the ports within one pair:

- On a write, it lands the word at the wrong regWrAddr on the very strobe that completes the pair.
- On a read, it shifts out the wrong upper byte in the first bit after the acknowledge.

A wrong bit counter or frame state shows within one byte time. The acknowledge slot either goes undriven or is driven in the wrong clock, and the next data byte is then mis-assembled. A wrong filter or edge detector adds or drops a bit. Every later byte of that transfer is then shifted, so a single spike corrupts the following write or read.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  // Strobes that the control sends to the datapath.
  typedef struct packed {
    logic shift;     // take in one bus bit
    logic loadPtr;   // received byte becomes the pointer
    logic latchMsb;  // received byte is held as the upper half
    logic commit;    // write {upper, received byte} and step the pointer
    logic incPtr;    // step the pointer (read continuation)
    logic capWord;   // capture the register word for transmission
  } strobes_t;

  // Frame states of the control.
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PTR, ST_WMSB, ST_WLSB, ST_RMSB, ST_RLSB, ST_SKIP
  } busState_t;

endpackage

// File: rtl/i2cw_filter.sv
module i2cw_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lineIn,
  output logic lineOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    syncR;
  logic [CW-1:0] cnt;

  // Two-flop synchronizer, then a level that must hold FILT_LEN cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncR   <= 2'b11;
      lineOut <= 1'b1;
      cnt     <= '0;
    end else begin
      syncR <= {syncR[0], lineIn};
      if (syncR[1] == lineOut) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        lineOut <= syncR[1];
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R9: the filtered level only moves toward the synchronized level
  assert_filter_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lineOut) |-> ($past(syncR[1]) == lineOut));

endmodule

// File: rtl/i2cw_dpath.sv
module i2cw_dpath
  import i2cw_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobes_t            stb,
  input  logic                sdaBit,
  input  logic [2*BYTE_W-1:0] regRdData,
  output logic [BYTE_W-1:0]   rxByte,
  output logic [2*BYTE_W-1:0] rdWord,
  output logic [BYTE_W-1:0]   regAddr,
  output logic                regWrEn,
  output logic [BYTE_W-1:0]   regWrAddr,
  output logic [2*BYTE_W-1:0] regWrData
);
  logic [BYTE_W-1:0] shiftReg, ptr, msbHold;

  assign rxByte  = {shiftReg[BYTE_W-2:0], sdaBit};
  assign regAddr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg  <= '0;
      ptr       <= '0;
      msbHold   <= '0;
      rdWord    <= '0;
      regWrEn   <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
    end else begin
      regWrEn <= 1'b0;
      if (stb.shift)    shiftReg <= rxByte;
      if (stb.loadPtr)  ptr      <= rxByte;
      if (stb.latchMsb) msbHold  <= rxByte;
      if (stb.commit) begin
        regWrEn   <= 1'b1;
        regWrAddr <= ptr;
        regWrData <= {msbHold, rxByte};
        ptr       <= ptr + 1'b1;
      end
      if (stb.incPtr)  ptr    <= ptr + 1'b1;
      if (stb.capWord) rdWord <= regRdData;
    end
  end

  // R3: a completed pair yields a single-cycle write strobe
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |=> !regWrEn);

  // R4: when a write appears, the pointer already sits one past it
  assert_ptr_past_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |-> (regAddr == regWrAddr + 1'b1));

endmodule

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
  import i2cw_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b01101,
  parameter logic [6:0] GEN_ADDR    = 7'b0001110,
  parameter int         BYTE_W      = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclF,
  input  logic                sdaF,
  input  logic [1:0]          strap,
  input  logic [BYTE_W-1:0]   rxByte,
  input  logic [2*BYTE_W-1:0] rdWord,
  output strobes_t            stb,
  output logic                sdaOe
);
  localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);

  busState_t   st;
  logic        sclPrev, sdaPrev, ackNow, mAckSlot, capPend;
  logic [3:0]  bitCnt;

  wire sclRise  = sclF & ~sclPrev;
  wire sclFall  = ~sclF & sclPrev;
  wire startDet = sclF & sclPrev & sdaPrev & ~sdaF;
  wire stopDet  = sclF & sclPrev & ~sdaPrev & sdaF;

  wire [6:0] ownAddr = {ADDR_PREFIX, strap};
  wire       addrHit = (rxByte[7:1] == ownAddr) || (rxByte[7:1] == GEN_ADDR);

  wire [BYTE_W-1:0] txByte = (st == ST_RMSB) ? rdWord[2*BYTE_W-1:BYTE_W]
                                             : rdWord[BYTE_W-1:0];
  wire [2:0]        txIdx  = 3'(BYTE_W - 1) - bitCnt[2:0];
  wire              inRead = (st == ST_RMSB) || (st == ST_RLSB);

  always_comb begin
    stb         = '0;
    stb.capWord = capPend;
    if (sclRise && st != ST_IDLE) begin
      if (bitCnt != ACK_SLOT) stb.shift = 1'b1;
      if (bitCnt == LAST_BIT) begin
        unique case (st)
          ST_ADDR: if (addrHit && rxByte[0]) stb.capWord = 1'b1;
          ST_PTR:  stb.loadPtr  = 1'b1;
          ST_WMSB: stb.latchMsb = 1'b1;
          ST_WLSB: stb.commit   = 1'b1;
          default: ;
        endcase
      end
      if (bitCnt == ACK_SLOT && mAckSlot && !sdaF && st == ST_RLSB)
        stb.incPtr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sclPrev <= 1'b1; sdaPrev <= 1'b1; sdaOe <= 1'b0;
      bitCnt <= '0; ackNow <= 1'b0; mAckSlot <= 1'b0; capPend <= 1'b0;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
      capPend <= 1'b0;
      if (stopDet) begin
        st <= ST_IDLE; sdaOe <= 1'b0; bitCnt <= '0; mAckSlot <= 1'b0; ackNow <= 1'b0;
      end else if (startDet) begin
        st <= ST_ADDR; sdaOe <= 1'b0; bitCnt <= '0; mAckSlot <= 1'b0; ackNow <= 1'b0;
      end else begin
        if (sclRise && st != ST_IDLE) begin
          bitCnt <= (bitCnt == ACK_SLOT) ? 4'd0 : 4'(bitCnt + 1'b1);
          if (bitCnt == LAST_BIT) begin
            ackNow   <= 1'b0;
            mAckSlot <= 1'b0;
            unique case (st)
              ST_ADDR: if (addrHit) begin
                         ackNow <= 1'b1;
                         st     <= rxByte[0] ? ST_RMSB : ST_PTR;
                       end else st <= ST_SKIP;
              ST_PTR:  begin ackNow <= 1'b1; st <= ST_WMSB; end
              ST_WMSB: begin ackNow <= 1'b1; st <= ST_WLSB; end
              ST_WLSB: begin ackNow <= 1'b1; st <= ST_WMSB; end
              ST_RMSB, ST_RLSB: mAckSlot <= 1'b1;
              default: ;
            endcase
          end
          if (bitCnt == ACK_SLOT && mAckSlot) begin
            if (sdaF)               st <= ST_SKIP;
            else if (st == ST_RMSB) st <= ST_RLSB;
            else begin st <= ST_RMSB; capPend <= 1'b1; end
          end
        end
        if (sclFall && st != ST_IDLE) begin
          if (bitCnt == ACK_SLOT) sdaOe <= ackNow;
          else if (inRead)        sdaOe <= ~txByte[txIdx];
          else                    sdaOe <= 1'b0;
        end
      end
    end
  end

  // R8: a stop leaves the line released and the frame idle
  assert_release_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stopDet |=> (!sdaOe && st == ST_IDLE));

  // R7: no drive while idle or after a refused/not-acknowledged transfer
  assert_quiet_when_skipped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP || st == ST_IDLE) |-> !sdaOe);

  // R6: the drive changes only while the clock is low
  assert_drive_moves_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdaOe) |-> !sclF);

endmodule

// File: rtl/i2c_word_slave.sv
module i2c_word_slave
  import i2cw_pkg::*;
#(
  parameter int         FILT_LEN    = 4,
  parameter logic [4:0] ADDR_PREFIX = 5'b01101,
  parameter logic [6:0] GEN_ADDR    = 7'b0001110
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        strapHi,
  input  logic        strapLo,
  output logic        sdaOe,
  output logic [7:0]  regAddr,
  input  logic [15:0] regRdData,
  output logic        regWrEn,
  output logic [7:0]  regWrAddr,
  output logic [15:0] regWrData
);
  localparam int BYTE_W = 8;
  localparam int NLINES = 2;

  logic [NLINES-1:0] rawLines, cleanLines;
  strobes_t          stb;
  logic [BYTE_W-1:0] rxByte;
  logic [15:0]       rdWord;

  // Line 1 is the clock, line 0 is the data.
  assign rawLines = {sclIn, sdaIn};

  for (genvar i = 0; i < NLINES; i++) begin : g_filt
    i2cw_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .lineIn(rawLines[i]), .lineOut(cleanLines[i]));
  end

  i2cw_ctrl #(.ADDR_PREFIX(ADDR_PREFIX), .GEN_ADDR(GEN_ADDR), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sclF(cleanLines[1]), .sdaF(cleanLines[0]),
    .strap({strapHi, strapLo}), .rxByte(rxByte), .rdWord(rdWord),
    .stb(stb), .sdaOe(sdaOe));

  i2cw_dpath #(.BYTE_W(BYTE_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .sdaBit(cleanLines[0]),
    .regRdData(regRdData), .rxByte(rxByte), .rdWord(rdWord),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData));

endmodule

// File: tb/tb_i2c_word_slave.sv
module tb_i2c_word_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic strapHi = 1'b1, strapLo = 1'b0;
  logic sdaOe, regWrEn;
  logic [7:0]  regAddr, regWrAddr;
  logic [15:0] regRdData, regWrData;
  logic        sdaLine;

  int checks = 0;
  int errors = 0;

  logic [15:0]  regModel [256];
  logic [255:0] written;
  logic [15:0]  shadow [256];
  logic [23:0]  wq [$];

  always #10 clk = ~clk;  // 50 MHz

  assign sdaLine   = sdaM & ~sdaOe;
  assign regRdData = written[regAddr] ? regModel[regAddr] : 16'h0000;

  i2c_word_slave dut (
    .clk(clk), .rst_n(rst_n), .sclIn(sclM), .sdaIn(sdaLine),
    .strapHi(strapHi), .strapLo(strapLo), .sdaOe(sdaOe),
    .regAddr(regAddr), .regRdData(regRdData), .regWrEn(regWrEn),
    .regWrAddr(regWrAddr), .regWrData(regWrData));

  // Register bank model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) written <= '0;
    else if (regWrEn) begin
      written[regWrAddr]  <= 1'b1;
      regModel[regWrAddr] <= regWrData;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: pops one expected write per strobe (R3, R4)
  always @(negedge clk) begin
    if (rst_n && regWrEn) begin
      if (wq.size() == 0) begin
        check(1'b0, "R3", "unexpected write", {regWrAddr, regWrData}, 0);
      end else begin
        logic [23:0] e;
        e = wq.pop_front();
        check({regWrAddr, regWrData} == e, "R3/R4", "write addr+data",
              {regWrAddr, regWrData}, e);
      end
    end
  end

  task automatic expectWrite(input logic [7:0] a, input logic [15:0] d);
    wq.push_back({a, d});
    shadow[a] = d;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; tick(10); sclM = 1'b1; tick(20);
    sdaM = 1'b0; tick(20); sclM = 1'b0; tick(10);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; tick(10); sclM = 1'b1; tick(20); sdaM = 1'b1; tick(20);
  endtask

  task automatic putBit(input bit b);
    sdaM = b; tick(10); sclM = 1'b1; tick(20); sclM = 1'b0; tick(10);
  endtask

  task automatic getBit(output bit b);
    sdaM = 1'b1; tick(10); sclM = 1'b1; tick(10); b = sdaLine;
    tick(10); sclM = 1'b0; tick(10);
  endtask

  task automatic sendByte(input logic [7:0] v, output bit acked);
    bit b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b);
    acked = !b;
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin getBit(b); v[i] = b; end
    putBit(!ackIt);
  endtask

  task automatic sclSpike();
    sclM = 1'b1; tick(2); sclM = 1'b0; tick(10);
  endtask

  localparam logic [6:0] OWN_A = 7'b0110110;  // prefix, strapHi=1, strapLo=0
  localparam logic [6:0] GEN_A = 7'b0001110;

  initial begin
    bit ack;
    logic [7:0] hi, lo;
    for (int i = 0; i < 256; i++) shadow[i] = 16'h0000;
    tick(5);
    // R10: reset state
    check(sdaOe == 1'b0, "R10", "sdaOe in reset", sdaOe, 0);
    check(regWrEn == 1'b0, "R10", "regWrEn in reset", regWrEn, 0);
    rst_n = 1'b1;
    tick(5);
    check(regAddr == 8'h00, "R10", "pointer after reset", regAddr, 0);

    // R1/R3/R4: strapped address, two pairs at 0x10
    startCond();
    sendByte({OWN_A, 1'b0}, ack); check(ack, "R1", "own address ack", ack, 1);
    sendByte(8'h10, ack);         check(ack, "R3", "pointer ack", ack, 1);
    expectWrite(8'h10, 16'hA55A);
    sendByte(8'hA5, ack);         check(ack, "R3", "upper byte ack", ack, 1);
    sendByte(8'h5A, ack);         check(ack, "R3", "lower byte ack", ack, 1);
    expectWrite(8'h11, 16'h1234);
    sendByte(8'h12, ack); sendByte(8'h34, ack);
    stopCond();

    // R1: non-matching address is ignored
    startCond();
    sendByte({7'b0110100, 1'b0}, ack); check(!ack, "R1", "foreign address nack", ack, 0);
    sendByte(8'h40, ack);              check(!ack, "R1", "no ack after mismatch", ack, 0);
    sendByte(8'hFF, ack); sendByte(8'hFF, ack);
    stopCond();

    // R2/R4/R9: generic address with other straps, wrap at 0xFF, spike on clock
    strapHi = 1'b0; strapLo = 1'b1;
    startCond();
    sendByte({GEN_A, 1'b0}, ack); check(ack, "R2", "generic address ack", ack, 1);
    sendByte(8'hFE, ack);
    sclSpike();  // R9: must not count as a bit
    expectWrite(8'hFE, 16'hC001);
    sendByte(8'hC0, ack); sendByte(8'h01, ack);
    expectWrite(8'hFF, 16'hBEEF);
    sendByte(8'hBE, ack); sendByte(8'hEF, ack);
    expectWrite(8'h00, 16'h7E57);  // R4 wrap
    sendByte(8'h7E, ack); sendByte(8'h57, ack);
    check(ack, "R9", "ack after filtered spike", ack, 1);
    stopCond();
    strapHi = 1'b1; strapLo = 1'b0;

    // R5: lone upper byte then stop
    startCond();
    sendByte({OWN_A, 1'b0}, ack); sendByte(8'h20, ack);
    sendByte(8'h99, ack);
    stopCond();

    // R8: stop in the middle of a lower byte
    startCond();
    sendByte({OWN_A, 1'b0}, ack); sendByte(8'h30, ack); sendByte(8'h66, ack);
    for (int i = 0; i < 4; i++) putBit(1'b0);
    stopCond();
    check(sdaOe == 1'b0, "R8", "released after stop", sdaOe, 0);
    check(wq.size() == 0, "R8", "no pending writes", wq.size(), 0);

    // R6/R7: read two words from 0x10 via repeated start
    startCond();
    sendByte({OWN_A, 1'b0}, ack); sendByte(8'h10, ack);
    startCond();
    sendByte({OWN_A, 1'b1}, ack); check(ack, "R6", "read address ack", ack, 1);
    recvByte(1'b1, hi); recvByte(1'b1, lo);
    check({hi, lo} == shadow[8'h10], "R6", "word 0x10", {hi, lo}, shadow[8'h10]);
    recvByte(1'b1, hi); recvByte(1'b0, lo);
    check({hi, lo} == shadow[8'h11], "R7", "word after ack", {hi, lo}, shadow[8'h11]);
    recvByte(1'b0, hi);
    check(hi == 8'hFF, "R7", "line released after nack", hi, 8'hFF);
    stopCond();
    check(regAddr == 8'h11, "R7", "pointer held on nack", regAddr, 8'h11);

    // R7: read from current pointer without write phase
    startCond();
    sendByte({OWN_A, 1'b1}, ack);
    recvByte(1'b1, hi); recvByte(1'b0, lo);
    check({hi, lo} == shadow[8'h11], "R7", "current-pointer read", {hi, lo}, shadow[8'h11]);
    stopCond();

    // R5/R2: read back the lone-byte target and the wrapped entry via generic address
    startCond();
    sendByte({GEN_A, 1'b0}, ack); sendByte(8'h20, ack);
    startCond();
    sendByte({GEN_A, 1'b1}, ack); check(ack, "R2", "generic read ack", ack, 1);
    recvByte(1'b0, hi); lo = 8'h00;
    stopCond();
    check(hi == 8'h00, "R5", "lone byte discarded", hi, 0);
    startCond();
    sendByte({OWN_A, 1'b0}, ack); sendByte(8'h00, ack);
    startCond();
    sendByte({OWN_A, 1'b1}, ack);
    recvByte(1'b1, hi); recvByte(1'b0, lo);
    check({hi, lo} == 16'h7E57, "R4", "wrapped word at 0x00", {hi, lo}, 16'h7E57);
    stopCond();

    tick(10);
    check(wq.size() == 0, "R3", "all expected writes seen", wq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule